// File: doc/BRIEF.md
# Compare-Match Timer with Self-Advancing Alarm

This block is a compare-match timer for a 64-bit free-running count supplied by an external system counter. It never counts by itself. Every decision follows the count it is given, so a counter that slows down, pauses or jumps moves the timer's match points with it. Software reaches the timer through a flat 32-bit register window. The window has a read-only view of the count, an absolute 64-bit compare value, a signed 32-bit relative view of that compare value, a control/status word and a second alarm. The second alarm moves itself forward by a programmed reload interval every time it fires.

In plain compare mode the status bit shows whether the count has reached the compare value. Once the self-advancing alarm is switched on, the status bit instead reports a sticky pending flag. That flag is set on each alarm hit and is cleared only by an explicit clear write. The interrupt output is a level. It is high while the timer is enabled, the status bit is set and the mask bit is clear.

Top module: `cmp_timer`

## Requirements
- R1: After reset the control word (0x2C), compare value, reload interval (0x48) and alarm control (0x4C) all read 0, and `irq_o` is low.
- R2: Address 0x00 returns bits 31:0 and address 0x04 returns bits 63:32 of the live count, including after the low word wraps. Address 0x10 returns the FREQ_VAL parameter.
- R3: The compare value is written and read as a low word at 0x20 and a high word at 0x24. Reading 0x28 returns the low 32 bits of (compare − count).
- R4: Writing V to 0x28 sets the compare value to count + V, with V sign-extended from 32 bits and count taken in the cycle of the write.
- R5: Control word 0x2C has enable in bit 0, mask in bit 1 and a read-only status in bit 2. While the alarm is off, status = enable AND (count ≥ compare), compared as unsigned 64-bit values.
- R6: `irq_o` = enable AND status AND NOT mask, with no delay from the count or the register state.
- R7: Alarm control 0x4C bit 0 switches the alarm on. A write with bit 0 = 1 while the alarm is off loads the alarm value with count + reload, where the 32-bit reload is zero-extended. The alarm value reads at 0x40 (low) and 0x44 (high). Reading 0x4C returns bit 0 only.
- R8: While the alarm is on, status equals the pending flag. At every clock edge where count ≥ alarm value, the pending flag sets and the alarm value grows by the reload interval.
- R9: Any write to 0x4C with bit 1 = 0 clears the pending flag, and a write with bit 1 = 1 leaves it alone. If an alarm hit falls in the same cycle as a clearing write, the flag stays set.
- R10: Unmapped addresses read 0. Writes to 0x00, 0x04, 0x10, 0x40 and 0x44 change nothing.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | 64 | Count from the external system counter |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
An alarm hit and a software clear of the pending flag can land on the same clock edge. A lost event there would go unnoticed by software. The bench watches the modelled alarm value, waits until the count it drives reaches that value and then issues the clearing write in exactly that cycle. The reference model sets the flag in that case and the control readback in the following cycle must show status set. A second overlap, a compare-register write in the same cycle that the count passes the old compare, is judged the same way on every clock against the model's status and interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int HI_W   = CNT_W - DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT_LO  = 8'h00,
        A_CNT_HI  = 8'h04,
        A_FREQ    = 8'h10,
        A_CMP_LO  = 8'h20,
        A_CMP_HI  = 8'h24,
        A_REL     = 8'h28,
        A_CTL     = 8'h2C,
        A_ALM_LO  = 8'h40,
        A_ALM_HI  = 8'h44,
        A_RELOAD  = 8'h48,
        A_ALM_CTL = 8'h4C
    } reg_addr_e;

    typedef struct packed {
        logic mask;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic cmp_lo;
        logic cmp_hi;
        logic rel;
        logic ctl;
        logic reload;
        logic alm_ctl;
    } wstb_t;

    function automatic logic [CNT_W-1:0] sext_word(input logic [DATA_W-1:0] v);
        return {{HI_W{v[DATA_W-1]}}, v};
    endfunction

    function automatic logic [CNT_W-1:0] zext_word(input logic [DATA_W-1:0] v);
        return {{HI_W{1'b0}}, v};
    endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output wstb_t             ws_o
);
    always_comb begin
        ws_o = '0;
        if (wr_i) begin
            case (addr_i)
                A_CMP_LO:  ws_o.cmp_lo  = 1'b1;
                A_CMP_HI:  ws_o.cmp_hi  = 1'b1;
                A_REL:     ws_o.rel     = 1'b1;
                A_CTL:     ws_o.ctl     = 1'b1;
                A_RELOAD:  ws_o.reload  = 1'b1;
                A_ALM_CTL: ws_o.alm_ctl = 1'b1;
                default:   ws_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
    parameter int W = 64
) (
    input  logic [W-1:0] now_i,
    input  logic [W-1:0] target_i,
    output logic         hit_o
);
    assign hit_o = (now_i >= target_i);
endmodule

// File: rtl/tmr_alarm.sv
module tmr_alarm
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic              ctl_we_i,
    input  logic [1:0]        ctl_bits_i,
    output logic              on_o,
    output logic [CNT_W-1:0]  value_o,
    output logic              pend_o
);
    logic             hit;
    logic             fire;
    logic [CNT_W-1:0] step;

    tmr_match #(.W(CNT_W)) u_hit (
        .now_i    (count_i),
        .target_i (value_o),
        .hit_o    (hit)
    );

    assign fire = on_o & hit;
    assign step = zext_word(reload_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            on_o    <= 1'b0;
            value_o <= '0;
            pend_o  <= 1'b0;
        end else begin
            if (ctl_we_i)
                on_o <= ctl_bits_i[0];
            if (ctl_we_i && ctl_bits_i[0] && !on_o)
                value_o <= count_i + step;
            else if (fire)
                value_o <= value_o + step;
            if (fire)
                pend_o <= 1'b1;
            else if (ctl_we_i && !ctl_bits_i[1])
                pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter logic [DATA_W-1:0] FREQ_VAL = 32'd50_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    wstb_t             ws;
    ctl_t              ctl_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [DATA_W-1:0] reload_q;
    logic              cmp_hit;
    logic              alm_on;
    logic [CNT_W-1:0]  alm_val;
    logic              alm_pend;
    logic              status;
    logic              ctl_en;
    logic              ctl_mask;

    tmr_decode u_dec (
        .addr_i (addr_i),
        .wr_i   (wr_i),
        .ws_o   (ws)
    );

    tmr_match #(.W(CNT_W)) u_cmp (
        .now_i    (count_i),
        .target_i (cmp_q),
        .hit_o    (cmp_hit)
    );

    tmr_alarm u_alm (
        .clk        (clk),
        .rst        (rst),
        .count_i    (count_i),
        .reload_i   (reload_q),
        .ctl_we_i   (ws.alm_ctl),
        .ctl_bits_i (wdata_i[1:0]),
        .on_o       (alm_on),
        .value_o    (alm_val),
        .pend_o     (alm_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            cmp_q    <= '0;
            reload_q <= '0;
        end else begin
            if (ws.cmp_lo)
                cmp_q[DATA_W-1:0] <= wdata_i;
            if (ws.cmp_hi)
                cmp_q[CNT_W-1:DATA_W] <= wdata_i;
            if (ws.rel)
                cmp_q <= count_i + sext_word(wdata_i);
            if (ws.ctl)
                ctl_q <= '{mask: wdata_i[1], en: wdata_i[0]};
            if (ws.reload)
                reload_q <= wdata_i;
        end
    end

    assign ctl_en   = ctl_q.en;
    assign ctl_mask = ctl_q.mask;
    assign status   = alm_on ? alm_pend : (ctl_q.en & cmp_hit);
    assign irq_o    = ctl_q.en & status & ~ctl_q.mask;

    always_comb begin
        case (addr_i)
            A_CNT_LO:  rdata_o = count_i[DATA_W-1:0];
            A_CNT_HI:  rdata_o = count_i[CNT_W-1:DATA_W];
            A_FREQ:    rdata_o = FREQ_VAL;
            A_CMP_LO:  rdata_o = cmp_q[DATA_W-1:0];
            A_CMP_HI:  rdata_o = cmp_q[CNT_W-1:DATA_W];
            A_REL:     rdata_o = cmp_q[DATA_W-1:0] - count_i[DATA_W-1:0];
            A_CTL:     rdata_o = {{(DATA_W-3){1'b0}}, status, ctl_q.mask, ctl_q.en};
            A_ALM_LO:  rdata_o = alm_val[DATA_W-1:0];
            A_ALM_HI:  rdata_o = alm_val[CNT_W-1:DATA_W];
            A_RELOAD:  rdata_o = reload_q;
            A_ALM_CTL: rdata_o = {{(DATA_W-1){1'b0}}, alm_on};
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  count_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              irq_o,
    input logic              en,
    input logic              mask,
    input logic              alm_on,
    input logic [CNT_W-1:0]  alm_val,
    input logic              alm_pend,
    input logic [CNT_W-1:0]  cmp,
    input logic [DATA_W-1:0] reload
);
    // R1
    irq_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_o);

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        mask |-> !irq_o);

    // R6
    irq_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !irq_o);

    // R4
    rel_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == 8'h28) |=> (cmp == $past(count_i) + sext_word($past(wdata_i))));

    // R8
    alarm_step_chk: assert property (@(posedge clk) disable iff (rst)
        (alm_on && count_i >= alm_val) |=>
            (alm_pend && alm_val == $past(alm_val) + zext_word($past(reload))));

    // R9
    alarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == 8'h4C && !wdata_i[1] && !(alm_on && count_i >= alm_val)) |=> !alm_pend);

    // R9
    alarm_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (alm_on && count_i >= alm_val && wr_i && addr_i == 8'h4C) |=> alm_pend);
endmodule

bind cmp_timer tmr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .count_i  (count_i),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .irq_o    (irq_o),
    .en       (ctl_en),
    .mask     (ctl_mask),
    .alm_on   (alm_on),
    .alm_val  (alm_val),
    .alm_pend (alm_pend),
    .cmp      (cmp_q),
    .reload   (reload_q)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] count_i = '0;
    logic [7:0]  addr_i = '0;
    logic        wr_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    cmp_timer i_cmp_timer (
        .clk     (clk),
        .rst     (rst),
        .count_i (count_i),
        .addr_i  (addr_i),
        .wr_i    (wr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // stimulus count source
    logic [63:0] cnt = '0;
    bit          run = 1'b0;
    int          div = 1;
    int          pre = 0;

    // reference model state
    logic [63:0] m_cmp, m_aval;
    logic [31:0] m_rl;
    bit          m_en, m_mask, m_aen, m_pend;

    function automatic bit m_stat();
        return m_aen ? m_pend : (m_en && (cnt >= m_cmp));
    endfunction

    function automatic bit m_irq();
        return m_en && m_stat() && !m_mask;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return cnt[31:0];
            8'h04: return cnt[63:32];
            8'h10: return 32'd50_000_000;
            8'h20: return m_cmp[31:0];
            8'h24: return m_cmp[63:32];
            8'h28: return m_cmp[31:0] - cnt[31:0];
            8'h2C: return {29'd0, m_stat(), m_mask, m_en};
            8'h40: return m_aval[31:0];
            8'h44: return m_aval[63:32];
            8'h48: return m_rl;
            8'h4C: return {31'd0, m_aen};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h04, 8'h10: return "R2";
            8'h20, 8'h24, 8'h28: return "R3";
            8'h2C: return "R5";
            8'h40, 8'h44, 8'h4C: return "R7";
            8'h48: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_cmp = '0; m_aval = '0; m_rl = '0;
        m_en = 0; m_mask = 0; m_aen = 0; m_pend = 0;
    endtask

    task automatic model_step(input logic [7:0] a, input bit w, input logic [31:0] d);
        bit          fire;
        bit          old_aen;
        logic [31:0] old_rl;
        fire    = m_aen && (cnt >= m_aval);
        old_aen = m_aen;
        old_rl  = m_rl;
        if (fire) begin
            m_aval = m_aval + {32'd0, old_rl};
            m_pend = 1;
        end
        if (w) begin
            case (a)
                8'h20: m_cmp[31:0] = d;
                8'h24: m_cmp[63:32] = d;
                8'h28: m_cmp = cnt + {{32{d[31]}}, d};
                8'h2C: begin m_en = d[0]; m_mask = d[1]; end
                8'h48: m_rl = d;
                8'h4C: begin
                    if (d[0] && !old_aen) m_aval = cnt + {32'd0, old_rl};
                    m_aen = d[0];
                    if (!fire && !d[1]) m_pend = 0;
                end
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t addr=%h actual=%h expected=%h", tag, $time, addr_i, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] a, input bit w, input logic [31:0] d);
        addr_i = a; wr_i = w; wdata_i = d; count_i = cnt;
        #1;
        if (!rst) begin
            chk(tag_of(a), rdata_o, m_read(a));
            chk("R6", {31'd0, irq_o}, {31'd0, m_irq()});
        end
        @(posedge clk);
        if (rst) model_reset();
        else model_step(a, w, d);
        if (run) begin
            if (div == 1) cnt = cnt + 1;
            else begin
                pre++;
                if (pre == div) begin pre = 0; cnt = cnt + 1; end
            end
        end
        @(negedge clk);
    endtask

    task automatic tick(input int n, input logic [7:0] a);
        for (int i = 0; i < n; i++) cyc(a, 0, 32'd0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(a, 1, d);
    endtask

    task automatic lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr_i = a; wr_i = 0; count_i = cnt;
        #1;
        chk(tag, rdata_o, exp);
        @(negedge clk);
        addr_i = a;
        #0;
    endtask

    initial begin
        @(negedge clk);
        rst = 1;
        tick(3, 8'h00);
        rst = 0;
        // R1 reset state against literal values
        lit(8'h2C, 32'd0, "R1");
        lit(8'h4C, 32'd0, "R1");
        lit(8'h48, 32'd0, "R1");
        lit(8'h20, 32'd0, "R1");
        chk("R1", {31'd0, irq_o}, 32'd0);

        // R2 count view and frequency
        run = 1;
        tick(100, 8'h00);
        tick(2, 8'h04);
        tick(2, 8'h10);
        lit(8'h10, 32'd50_000_000, "R2");

        // R3 / R5 absolute compare
        wr(8'h2C, 32'd1);
        wr(8'h20, 32'd400);
        wr(8'h24, 32'd0);
        tick(3, 8'h28);
        tick(300, 8'h2C);
        tick(3, 8'h28);

        // R6 mask
        wr(8'h2C, 32'd3);
        tick(5, 8'h2C);
        wr(8'h2C, 32'd1);

        // R4 relative writes, negative and positive
        wr(8'h28, 32'hFFFF_FFFB);
        tick(3, 8'h2C);
        wr(8'h28, 32'd50);
        tick(60, 8'h2C);
        tick(2, 8'h28);

        // R7 / R8 alarm load and self-advance
        wr(8'h48, 32'd200);
        wr(8'h4C, 32'd1);
        tick(2, 8'h40);
        tick(2, 8'h44);
        tick(450, 8'h2C);
        // R9 bit1 = 1 keeps pending, bit1 = 0 clears
        wr(8'h4C, 32'd3);
        tick(2, 8'h2C);
        wr(8'h4C, 32'd1);
        tick(2, 8'h2C);

        // R9 hit and clear in the same cycle
        wr(8'h48, 32'd10);
        tick(250, 8'h2C);
        wr(8'h4C, 32'd1);
        while (cnt < m_aval) tick(1, 8'h2C);
        wr(8'h4C, 32'd1);
        tick(3, 8'h2C);

        // R2 / R7 / R8 across the low-word wrap
        wr(8'h4C, 32'd0);
        cnt = 64'h0000_0041_FFFF_FF00;
        tick(300, 8'h00);
        tick(2, 8'h04);
        cnt = 64'h0000_0042_FFFF_FF80;
        wr(8'h48, 32'h80);
        wr(8'h4C, 32'd1);
        tick(300, 8'h44);
        tick(100, 8'h40);
        wr(8'h4C, 32'd0);

        // R5 slowed count source delays the match sixteenfold
        div = 16;
        wr(8'h28, 32'd100);
        tick(1550, 8'h2C);
        tick(150, 8'h2C);
        div = 1;

        // R10 unmapped reads and read-only writes
        tick(2, 8'h08);
        tick(2, 8'h50);
        wr(8'h00, 32'h1234_5678);
        wr(8'h40, 32'h1234_5678);
        wr(8'h44, 32'h1234_5678);
        wr(8'h10, 32'h1);
        tick(2, 8'h40);
        tick(2, 8'h44);
        tick(2, 8'h10);
        lit(8'h10, 32'd50_000_000, "R10");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule